// File: doc/BRIEF.md
# 1-Wire Device-Side Slot Responder

This block sits behind a single open-drain data line and behaves as the device end of a 1-Wire link. It watches the synchronized line level and times every low period with its own clock-cycle counter. A long low period is taken as a bus reset, and the block answers with a presence pulse after a short wait. Shorter low periods are taken as time slots. Write slots are decoded into received bits. In read slots the block sends a prepared bit by holding the line low for a set time, or by leaving it alone.

The surrounding logic decides the direction of each slot. It presents `tx_en` and `tx_bit` before the master's falling edge. Both are captured when the slot starts. The block reports a completed write slot with `rx_strobe` and `rx_bit`, a completed read slot with `tx_strobe`, and a recognized reset with `reset_strobe`. A low period that is longer than a slot but shorter than a reset is discarded. The next falling edge then starts a fresh slot.

Top module: `ow_slot_responder`

## Requirements
- R1: After reset deassertion, `bus_pull` is 0 and none of `rx_strobe`, `tx_strobe` or `reset_strobe` pulses while the line stays high.
- R2: A low period of at least RESET_US ends, at the rising edge, with one `reset_strobe` pulse. The line is not driven for PRES_WAIT_US after that pulse.
- R3: After the wait, `bus_pull` is 1 for exactly PRES_LOW_US*CLK_PER_US clock cycles and is then released.
- R4: In a write slot (`tx_en`=0 at the falling edge), a line that is high at SAMPLE_US after the fall gives one `rx_strobe` with `rx_bit`=1.
- R5: In a write slot, a line that is still low at SAMPLE_US after the fall gives one `rx_strobe` with `rx_bit`=0 once the line rises, provided the low time is at most SLOT_MAX_US.
- R6: In a read slot (`tx_en`=1) with `tx_bit`=0, `bus_pull` rises on the cycle the slot starts and stays high for READ0_US. The slot ends with one `tx_strobe` and no `rx_strobe`.
- R7: In a read slot with `tx_bit`=1, `bus_pull` stays 0 for the whole slot. The slot ends with one `tx_strobe`.
- R8: A low period longer than SLOT_MAX_US and shorter than RESET_US produces no strobe and no drive. The next falling edge starts a fresh slot that decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock and time base |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Sensed level of the open-drain data line |
| bus_pull | output | 1 | 1 = pull the data line low |
| tx_en | input | 1 | 1 = next slot is a read slot, sampled at its falling edge |
| tx_bit | input | 1 | Bit to send in the next read slot, sampled at its falling edge |
| rx_strobe | output | 1 | One-cycle pulse: a write slot was decoded |
| rx_bit | output | 1 | Value of the last decoded write bit |
| tx_strobe | output | 1 | One-cycle pulse: a read slot completed |
| reset_strobe | output | 1 | One-cycle pulse: a bus reset was recognized |

## Verification
The bench builds the block with CLK_PER_US=2 and all durations scaled down by ten. This gives a 96-cycle reset threshold, a 24-cycle slot limit and a 6-cycle sample point. Every phase, including the presence wait and the overlong-low discard, therefore fits in a few dozen cycles. Because the scaled windows are short, the bench can count the exact presence width in cycles. It also places its write-0, framing-error and reset low times clearly on either side of each threshold.

// File: rtl/ow_slot_responder.sv
module ow_slot_responder #(
  parameter int CLK_PER_US   = 50,
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LOW_US  = 120,
  parameter int SAMPLE_US    = 30,
  parameter int READ0_US     = 30,
  parameter int SLOT_MAX_US  = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic bus_pull,
  input  logic tx_en,
  input  logic tx_bit,
  output logic rx_strobe,
  output logic rx_bit,
  output logic tx_strobe,
  output logic reset_strobe
);
  localparam int RST_C  = RESET_US * CLK_PER_US;
  localparam int PWT_C  = PRES_WAIT_US * CLK_PER_US;
  localparam int PLO_C  = PRES_LOW_US * CLK_PER_US;
  localparam int SMP_C  = SAMPLE_US * CLK_PER_US;
  localparam int RD0_C  = READ0_US * CLK_PER_US;
  localparam int SLT_C  = SLOT_MAX_US * CLK_PER_US;
  localparam int MAX_C  = (RST_C > PLO_C) ? RST_C : PLO_C;
  localparam int CW     = $clog2(MAX_C + 1);

  localparam logic [CW-1:0] K_RST = CW'(RST_C);
  localparam logic [CW-1:0] K_PWT = CW'(PWT_C - 1);
  localparam logic [CW-1:0] K_PLO = CW'(PLO_C - 1);
  localparam logic [CW-1:0] K_SMP = CW'(SMP_C);
  localparam logic [CW-1:0] K_RD0 = CW'(RD0_C);
  localparam logic [CW-1:0] K_SLT = CW'(SLT_C);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SLOT, ST_PWAIT, ST_PLOW, ST_PREL
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [2:0]    sync;
  logic          slot_rd, slot_txb;

  wire lvl  = sync[1];
  wire fall = sync[2] & ~sync[1];

  assign bus_pull = (state == ST_PLOW) ||
                    (state == ST_SLOT && slot_rd && !slot_txb && cnt < K_RD0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync         <= 3'b111;
      state        <= ST_IDLE;
      cnt          <= '0;
      slot_rd      <= 1'b0;
      slot_txb     <= 1'b1;
      rx_strobe    <= 1'b0;
      rx_bit       <= 1'b0;
      tx_strobe    <= 1'b0;
      reset_strobe <= 1'b0;
    end else begin
      sync         <= {sync[1:0], line_in};
      rx_strobe    <= 1'b0;
      tx_strobe    <= 1'b0;
      reset_strobe <= 1'b0;
      case (state)
        ST_IDLE: if (fall) begin
          state    <= ST_SLOT;
          cnt      <= '0;
          slot_rd  <= tx_en;
          slot_txb <= tx_bit;
        end
        ST_SLOT: begin
          if (cnt != K_RST) cnt <= cnt + 1'b1;
          if (lvl && cnt >= K_SMP) begin
            cnt <= '0;
            if (cnt >= K_RST) begin
              state        <= ST_PWAIT;
              reset_strobe <= 1'b1;
            end else begin
              state <= ST_IDLE;
              if (cnt <= K_SLT) begin
                if (slot_rd) tx_strobe <= 1'b1;
                else begin
                  rx_strobe <= 1'b1;
                  rx_bit    <= (cnt == K_SMP);
                end
              end
            end
          end
        end
        ST_PWAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == K_PWT) begin
            state <= ST_PLOW;
            cnt   <= '0;
          end
        end
        ST_PLOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == K_PLO) begin
            state <= ST_PREL;
            cnt   <= '0;
          end
        end
        ST_PREL: if (lvl) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_slot_responder_chk.sv
module ow_slot_responder_chk #(
  parameter int CW    = 8,
  parameter int PLO_C = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_pull,
  input logic          rx_strobe,
  input logic          tx_strobe,
  input logic          reset_strobe,
  input logic [2:0]    state,
  input logic [CW-1:0] cnt,
  input logic          slot_rd,
  input logic          slot_txb
);
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!bus_pull && !rx_strobe && !tx_strobe && !reset_strobe));

  assert_one_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_strobe, tx_strobe, reset_strobe}) <= 1);

  assert_wait_before_presence_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_strobe |=> !bus_pull);

  assert_drive_starts_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_pull) |-> (cnt == '0));

  assert_read1_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1 && slot_rd && slot_txb) |-> !bus_pull);

  assert_presence_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_pull) && $past(state) == 3'd3) |-> ($past(cnt) == CW'(PLO_C - 1)));
endmodule

bind ow_slot_responder ow_slot_responder_chk #(.CW(CW), .PLO_C(PLO_C)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_pull(bus_pull), .rx_strobe(rx_strobe),
  .tx_strobe(tx_strobe), .reset_strobe(reset_strobe), .state(state),
  .cnt(cnt), .slot_rd(slot_rd), .slot_txb(slot_txb)
);

// File: tb/tb_ow_slot_responder.sv
`timescale 1ns/1ps
module tb_ow_slot_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_pull = 1'b0;
  logic tx_en = 1'b0, tx_bit = 1'b1;
  logic bus_pull, rx_strobe, rx_bit, tx_strobe, reset_strobe;
  wire  line = ~(m_pull | bus_pull);

  int tests = 0, fails = 0;
  int n_rx = 0, n_tx = 0, n_rst = 0, n_pull = 0;

  always #5 clk = ~clk;

  ow_slot_responder #(
    .CLK_PER_US(2), .RESET_US(48), .PRES_WAIT_US(3), .PRES_LOW_US(12),
    .SAMPLE_US(3), .READ0_US(3), .SLOT_MAX_US(12)
  ) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line), .bus_pull(bus_pull),
    .tx_en(tx_en), .tx_bit(tx_bit), .rx_strobe(rx_strobe), .rx_bit(rx_bit),
    .tx_strobe(tx_strobe), .reset_strobe(reset_strobe)
  );

  always @(posedge clk) begin
    if (rx_strobe) n_rx <= n_rx + 1;
    if (tx_strobe) n_tx <= n_tx + 1;
    if (reset_strobe) n_rst <= n_rst + 1;
    if (bus_pull) n_pull <= n_pull + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_low(input int n);
    @(negedge clk); m_pull = 1'b1;
    cyc(n); m_pull = 1'b0;
  endtask

  task automatic t_reset_state;
    cyc(20);
    check("R1 pull", int'(bus_pull), 0);
    check("R1 strobes", n_rx + n_tx + n_rst, 0);
  endtask

  task automatic t_bus_reset;
    int r0, p0;
    r0 = n_rst; p0 = n_pull;
    master_low(110);
    cyc(4);
    check("R2 reset strobe", n_rst - r0, 1);
    check("R2 wait released", n_pull - p0, 0);
    cyc(11);
    check("R3 presence driving", int'(line), 0);
    cyc(25);
    check("R3 presence released", int'(bus_pull), 0);
    check("R3 presence width", n_pull - p0, 24);
    cyc(5);
  endtask

  task automatic t_write1;
    int r0;
    r0 = n_rx;
    tx_en = 1'b0;
    master_low(2);
    cyc(30);
    check("R4 rx count", n_rx - r0, 1);
    check("R4 rx bit", int'(rx_bit), 1);
  endtask

  task automatic t_write0;
    int r0;
    r0 = n_rx;
    tx_en = 1'b0;
    master_low(18);
    cyc(20);
    check("R5 rx count", n_rx - r0, 1);
    check("R5 rx bit", int'(rx_bit), 0);
  endtask

  task automatic t_read0;
    int r0, t0, p0;
    r0 = n_rx; t0 = n_tx; p0 = n_pull;
    tx_en = 1'b1; tx_bit = 1'b0;
    master_low(4);
    cyc(2);
    check("R6 line held", int'(line), 0);
    cyc(20);
    check("R6 released", int'(line), 1);
    check("R6 drive width", n_pull - p0, 6);
    check("R6 tx strobe", n_tx - t0, 1);
    check("R6 no rx", n_rx - r0, 0);
    tx_en = 1'b0; tx_bit = 1'b1;
  endtask

  task automatic t_read1;
    int t0, p0;
    t0 = n_tx; p0 = n_pull;
    tx_en = 1'b1; tx_bit = 1'b1;
    master_low(4);
    cyc(25);
    check("R7 no drive", n_pull - p0, 0);
    check("R7 tx strobe", n_tx - t0, 1);
    tx_en = 1'b0;
  endtask

  task automatic t_framing;
    int r0, t0, s0, p0;
    r0 = n_rx; t0 = n_tx; s0 = n_rst; p0 = n_pull;
    tx_en = 1'b0;
    master_low(60);
    cyc(40);
    check("R8 no strobe", (n_rx - r0) + (n_tx - t0) + (n_rst - s0), 0);
    check("R8 no drive", n_pull - p0, 0);
    master_low(2);
    cyc(30);
    check("R8 fresh slot rx", n_rx - r0, 1);
    check("R8 fresh slot bit", int'(rx_bit), 1);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    t_reset_state();
    t_bus_reset();
    t_write1();
    t_write0();
    t_read0();
    t_read1();
    t_framing();
    t_write0();
    t_bus_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule